// File: doc/BRIEF.md
# Supervisory Reset Controller with Shared Pushbutton Line

This block owns an active-low system reset line. It drives the line low through an open-drain style output (`rst_drive_low`) and reads the resulting level back through `rst_line_in`. Three things can start a reset cycle. A power-fail input holds reset for as long as it is active, and then for a fixed stretch after it clears. A watchdog request produces one stretch of fixed length. A pushbutton wired onto the same line is debounced by the block itself. While any cycle is running, or whenever the line reads low, `access_block` tells the rest of the chip to refuse register traffic. All durations are counted in ticks of a slow time base (`tick`) and set by parameters.

The behaviour is one state machine. Its states are:
- ST_IDLE: the line is released.
- ST_PF_HOLD: power is failing.
- ST_OSC_WAIT: power is back and the oscillator is still starting.
- ST_PULSE: the fixed reset stretch.
- ST_DEBOUNCE: the line is pulled low for the debounce window.
- ST_SETTLE: the drive is released and the block waits a few clocks for the synchronizer.
- ST_WAIT_REL: the button is still held.

The transitions are:
- From any state, power-fail goes to ST_PF_HOLD.
- From ST_IDLE, a watchdog request goes to ST_PULSE. Otherwise a falling line edge goes to ST_DEBOUNCE.
- From ST_PF_HOLD, when power returns, the block goes to ST_OSC_WAIT if the oscillator-hold option is set and start-up is not complete. Otherwise it goes to ST_PULSE.
- From ST_OSC_WAIT, start-up complete goes to ST_PULSE.
- From ST_PULSE, the end of the stretch goes to ST_IDLE.
- From ST_DEBOUNCE, the end of the window goes to ST_SETTLE.
- From ST_SETTLE, the end of the settle count goes to ST_PULSE if the line is high, or to ST_WAIT_REL if it is low.
- From ST_WAIT_REL, the line going high goes to ST_PULSE.

Top module: `sup_rst_ctrl`

## Requirements
- R1: After the block's own reset, `rst_drive_low` is 0 and `access_block` is 0.
- R2: In the clock cycle after `pwr_fail` is sampled high, `rst_drive_low` and `access_block` are both 1, and they stay 1 while `pwr_fail` stays high.
- R3: With `osc_hold_en` = 0, after `pwr_fail` falls the drive stays low for exactly TRST_TICKS ticks and is then released. The drive is only ever released on a cycle in which `tick` was high.
- R4: With `osc_hold_en` = 1 and `osc_ready` = 0 when `pwr_fail` falls, the drive stays low until `osc_ready` rises. It then stays low for a further TRST_TICKS ticks.
- R5: A `wdog_req` sampled in ST_IDLE drives the line low from the next cycle for exactly TRST_TICKS ticks.
- R6: A falling edge on the synchronized line in ST_IDLE pulls the line low for exactly DEB_TICKS ticks.
- R7: After the debounce window, if the line is still low the drive is released and the block waits for release. Whether or not the button was still held, a TRST_TICKS stretch follows, so a press yields DEB_TICKS + TRST_TICKS driven ticks.
- R8: `access_block` is 1 whenever `rst_drive_low` is 1, and also while the block waits for the button to be released.
- R9: `pwr_fail` aborts any debounce, wait or pulse phase and enters the power-fail hold. Afterwards only the TRST_TICKS stretch follows. The drive is never released in a cycle after `pwr_fail` was high.
- R10: Line edges caused by the block's own drive never start a debounce. After a stretch ends, the line stays released and `access_block` returns to 0.
- R11: A `wdog_req` outside ST_IDLE is ignored. During a button wait it does not drive the line and does not lengthen the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block's own state |
| tick | input | 1 | One-cycle pulse from the slow time base; all delays count these |
| pwr_fail | input | 1 | High while supply is out of tolerance |
| osc_hold_en | input | 1 | Oscillator-hold option: power-return hold also waits for start-up |
| osc_ready | input | 1 | Oscillator start-up complete |
| wdog_req | input | 1 | Watchdog expiry request, one cycle |
| rst_line_in | input | 1 | Sensed level of the shared reset line (asynchronous) |
| rst_drive_low | output | 1 | 1 pulls the shared reset line low |
| access_block | output | 1 | 1 while register access must be refused |

## Verification
The properties assume that `pwr_fail`, `wdog_req`, `tick` and the oscillator inputs are synchronous to `clk`. They also assume that `tick` never lasts longer than one cycle at a time, and that the reset line is a wired-AND of the block's drive and the button. The bench models the line exactly that way. It produces `tick` from a clock divider, and changes every stimulus on a falling clock edge in a cycle where `tick` is low. As a result, no request collides with a tick, and every driven-tick count has a single expected value.

// File: rtl/sup_rst_pkg.sv
package sup_rst_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PF_HOLD,
        ST_OSC_WAIT,
        ST_PULSE,
        ST_DEBOUNCE,
        ST_SETTLE,
        ST_WAIT_REL
    } sup_state_e;
endpackage

// File: rtl/sup_line_sync.sv
// Two-flop synchronizer on the sensed line, with falling-edge detection.
// Edges that the block caused itself are masked using a short history of the drive.
module sup_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    input  logic drive_low,
    output logic line_hi,
    output logic line_fall
);
    localparam int HIST = STAGES + 1;

    logic [STAGES-1:0] sync_q;
    logic              prev_q;
    logic [HIST-1:0]   drv_hist_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q     <= '1;
            prev_q     <= 1'b1;
            drv_hist_q <= '0;
        end else begin
            sync_q     <= {sync_q[STAGES-2:0], line_in};
            prev_q     <= sync_q[STAGES-1];
            drv_hist_q <= {drv_hist_q[HIST-2:0], drive_low};
        end
    end

    assign line_hi   = sync_q[STAGES-1];
    assign line_fall = prev_q && !sync_q[STAGES-1] && !(|drv_hist_q) && !drive_low;
endmodule

// File: rtl/sup_tick_cnt.sv
// Counter of increments that restarts on clear. done marks the increment that reaches the limit.
module sup_tick_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    input  logic [W-1:0] limit,
    output logic         done
);
    logic [W-1:0] cnt_q;

    assign done = inc && (cnt_q == limit - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (clr)    cnt_q <= '0;
        else if (done)   cnt_q <= '0;
        else if (inc)    cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/sup_rst_fsm.sv
module sup_rst_fsm
    import sup_rst_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int TRST_TICKS = 170,
    parameter int DEB_TICKS  = 170,
    parameter int SETTLE_CYC = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             pwr_fail,
    input  logic             osc_hold_en,
    input  logic             osc_ready,
    input  logic             wdog_req,
    input  logic             line_hi,
    input  logic             line_fall,
    input  logic             cnt_done,
    output logic             cnt_clr,
    output logic             cnt_inc,
    output logic [CNT_W-1:0] cnt_limit,
    output logic             drive_low,
    output logic             busy
);
    localparam logic [CNT_W-1:0] LIM_RST    = CNT_W'(TRST_TICKS);
    localparam logic [CNT_W-1:0] LIM_DEB    = CNT_W'(DEB_TICKS);
    localparam logic [CNT_W-1:0] LIM_SETTLE = CNT_W'(SETTLE_CYC);

    sup_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (pwr_fail) begin
            state_d = ST_PF_HOLD;
        end else begin
            unique case (state_q)
                ST_IDLE:     if (wdog_req)       state_d = ST_PULSE;
                             else if (line_fall) state_d = ST_DEBOUNCE;
                ST_PF_HOLD:  state_d = (osc_hold_en && !osc_ready) ? ST_OSC_WAIT : ST_PULSE;
                ST_OSC_WAIT: if (osc_ready)      state_d = ST_PULSE;
                ST_PULSE:    if (cnt_done)       state_d = ST_IDLE;
                ST_DEBOUNCE: if (cnt_done)       state_d = ST_SETTLE;
                ST_SETTLE:   if (cnt_done)       state_d = line_hi ? ST_PULSE : ST_WAIT_REL;
                ST_WAIT_REL: if (line_hi)        state_d = ST_PULSE;
                default:                         state_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        cnt_clr   = (state_d != state_q);
        cnt_inc   = (state_q == ST_SETTLE) ? 1'b1 : tick;
        unique case (state_q)
            ST_DEBOUNCE: cnt_limit = LIM_DEB;
            ST_SETTLE:   cnt_limit = LIM_SETTLE;
            default:     cnt_limit = LIM_RST;
        endcase
        drive_low = (state_q == ST_PF_HOLD) || (state_q == ST_OSC_WAIT) ||
                    (state_q == ST_PULSE)   || (state_q == ST_DEBOUNCE);
        busy      = (state_q != ST_IDLE);
    end
endmodule

// File: rtl/sup_rst_ctrl.sv
module sup_rst_ctrl #(
    parameter int TRST_TICKS  = 170,
    parameter int DEB_TICKS   = 170,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic pwr_fail,
    input  logic osc_hold_en,
    input  logic osc_ready,
    input  logic wdog_req,
    input  logic rst_line_in,
    output logic rst_drive_low,
    output logic access_block
);
    localparam int SETTLE_CYC = SYNC_STAGES + 1;
    localparam int MAX_LIM    = (TRST_TICKS > DEB_TICKS) ?
                                ((TRST_TICKS > SETTLE_CYC) ? TRST_TICKS : SETTLE_CYC) :
                                ((DEB_TICKS  > SETTLE_CYC) ? DEB_TICKS  : SETTLE_CYC);
    localparam int CNT_W      = $clog2(MAX_LIM + 1);

    logic             line_hi, line_fall;
    logic             cnt_clr, cnt_inc, cnt_done, busy;
    logic [CNT_W-1:0] cnt_limit;

    sup_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .line_in(rst_line_in), .drive_low(rst_drive_low),
        .line_hi(line_hi), .line_fall(line_fall)
    );

    sup_tick_cnt #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc),
        .limit(cnt_limit), .done(cnt_done)
    );

    sup_rst_fsm #(
        .CNT_W(CNT_W), .TRST_TICKS(TRST_TICKS), .DEB_TICKS(DEB_TICKS), .SETTLE_CYC(SETTLE_CYC)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(tick), .pwr_fail(pwr_fail),
        .osc_hold_en(osc_hold_en), .osc_ready(osc_ready), .wdog_req(wdog_req),
        .line_hi(line_hi), .line_fall(line_fall), .cnt_done(cnt_done),
        .cnt_clr(cnt_clr), .cnt_inc(cnt_inc), .cnt_limit(cnt_limit),
        .drive_low(rst_drive_low), .busy(busy)
    );

    assign access_block = busy || !line_hi;
endmodule

// File: rtl/sup_rst_chk.sv
module sup_rst_chk (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic pwr_fail,
    input logic wdog_req,
    input logic rst_drive_low,
    input logic access_block
);
    p_pf_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fail |=> (rst_drive_low && access_block));

    p_drive_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_drive_low |-> access_block);

    p_wd_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wdog_req && !access_block && !pwr_fail) |=> rst_drive_low);

    p_release_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_drive_low) |-> $past(tick));

    p_no_release_in_pf_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_drive_low) |-> !$past(pwr_fail));
endmodule

bind sup_rst_ctrl sup_rst_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pwr_fail(pwr_fail),
    .wdog_req(wdog_req), .rst_drive_low(rst_drive_low), .access_block(access_block)
);

// File: tb/tb_sup_rst_ctrl.sv
module tb_sup_rst_ctrl;
    localparam int TRST = 20;
    localparam int DEB  = 12;
    localparam int WATCHDOG_CYC = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick;
    logic pwr_fail = 1'b0;
    logic osc_hold_en = 1'b0;
    logic osc_ready = 1'b1;
    logic wdog_req = 1'b0;
    logic btn = 1'b0;
    logic rst_line_in;
    logic rst_drive_low, access_block;
    logic [1:0] tdiv = 2'd1;
    int   cyc = 0;
    int   lowticks = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done_flag = 1'b0;

    always #10 clk = ~clk;

    assign rst_line_in = ~(rst_drive_low | btn);
    assign tick = (tdiv == 2'd0);

    always @(posedge clk) begin
        tdiv <= tdiv + 2'd1;
        cyc  <= cyc + 1;
    end

    always @(negedge clk)
        if (tick && rst_drive_low && !pwr_fail) lowticks <= lowticks + 1;

    sup_rst_ctrl #(.TRST_TICKS(TRST), .DEB_TICKS(DEB)) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .pwr_fail(pwr_fail),
        .osc_hold_en(osc_hold_en), .osc_ready(osc_ready), .wdog_req(wdog_req),
        .rst_line_in(rst_line_in), .rst_drive_low(rst_drive_low), .access_block(access_block)
    );

    function automatic int exp_press();
        return DEB + TRST;
    endfunction

    function automatic int exp_power(input int wait_ticks);
        return wait_ticks + TRST;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic quiet();
        @(negedge clk);
        while (tick) @(negedge clk);
    endtask

    task automatic wait_free(input string req);
        int guard = 0;
        do begin
            @(negedge clk);
            guard++;
        end while (access_block && guard < 20000);
        check(!rst_drive_low && !access_block, req, int'(access_block), 0);
        repeat (12) @(negedge clk);
        check(!access_block && !rst_drive_low, "R10", int'(access_block), 0);
    endtask

    task automatic run_wd();
        quiet();
        lowticks = 0;
        wdog_req = 1'b1;
        @(negedge clk);
        wdog_req = 1'b0;
        check(rst_drive_low, "R5", int'(rst_drive_low), 1);
        wait_free("R5");
        check(lowticks == TRST, "R5", lowticks, TRST);
    endtask

    task automatic run_pf(input int hold, input bit osc, input int wait_cyc);
        int k;
        quiet();
        osc_hold_en = osc;
        osc_ready   = !osc;
        pwr_fail    = 1'b1;
        @(negedge clk);
        check(rst_drive_low && access_block, "R2", int'(rst_drive_low), 1);
        repeat (hold) @(negedge clk);
        check(rst_drive_low, "R2", int'(rst_drive_low), 1);
        quiet();
        lowticks = 0;
        pwr_fail = 1'b0;
        k = 0;
        if (osc) begin
            repeat (wait_cyc) @(negedge clk);
            quiet();
            check(rst_drive_low, "R4", int'(rst_drive_low), 1);
            k = lowticks;
            osc_ready = 1'b1;
        end
        wait_free(osc ? "R4" : "R3");
        check(lowticks == exp_power(k), osc ? "R4" : "R3", lowticks, exp_power(k));
        osc_hold_en = 1'b0;
    endtask

    task automatic run_press(input int hold, input bit poke_wd);
        quiet();
        lowticks = 0;
        btn = 1'b1;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            if (i == 8) check(rst_drive_low && access_block, "R6", int'(rst_drive_low), 1);
            if (poke_wd && i == hold - 10) wdog_req = 1'b1;
            if (poke_wd && i == hold - 9) begin
                wdog_req = 1'b0;
                check(!rst_drive_low, "R11", int'(rst_drive_low), 0);
            end
        end
        quiet();
        if (hold > DEB * 4 + 20)
            check(!rst_drive_low && access_block, "R7", int'(rst_drive_low), 0);
        btn = 1'b0;
        wait_free("R7");
        check(lowticks == exp_press(), poke_wd ? "R11" : "R7", lowticks, exp_press());
    endtask

    task automatic run_abort();
        quiet();
        btn = 1'b1;
        repeat (20) @(negedge clk);
        pwr_fail = 1'b1;
        repeat (10) @(negedge clk);
        check(rst_drive_low, "R9", int'(rst_drive_low), 1);
        btn = 1'b0;
        repeat (6) @(negedge clk);
        quiet();
        lowticks = 0;
        pwr_fail = 1'b0;
        wait_free("R9");
        check(lowticks == TRST, "R9", lowticks, TRST);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!rst_drive_low && !access_block, "R1", int'(rst_drive_low), 0);

        run_wd();
        run_pf(30, 1'b0, 0);
        run_pf(15, 1'b1, 60);
        run_press(3, 1'b0);
        run_press(40, 1'b0);
        run_press(150, 1'b0);
        run_press(160, 1'b1);
        run_abort();

        for (int it = 0; it < 30; it++) begin
            case ($urandom % 5)
                0: run_wd();
                1: run_pf(1 + int'($urandom % 50), 1'b0, 0);
                2: run_pf(1 + int'($urandom % 50), 1'b1, 1 + int'($urandom % 80));
                3: run_press(1 + int'($urandom % 200), 1'b0);
                default: run_abort();
            endcase
        end

        done_flag = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        if (cyc > WATCHDOG_CYC && !done_flag) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, WATCHDOG_CYC);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule